// File: doc/BRIEF.md
# GPIO Pin Interrupt Trigger Unit

This block turns the eight input pins of a general-purpose I/O port into one processor interrupt. Each pin is first brought into the clock domain by a two-flop synchronizer. A per-pin 3-bit trigger mode then decides how the pin contributes. It can be silent, follow a level, be forced on for software test, or latch rising, falling or any edges into a sticky pending bit.

Software reaches the unit through a simple word-addressed register bus with single-cycle read and write strobes. It programs the trigger modes and an enable mask, reads the raw and the masked pending views, and clears latched edges by writing ones to an acknowledge register. The unit drives a single interrupt line. That line is the registered OR of every enabled pending pin.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, the trigger configuration, the mask, all pending status and `irq_o` are zero.
- R2: A read at offset 4 returns the pin inputs in bits 7:0 after a two-flop synchronizer, so a pin change appears two clock edges after it is applied.
- R3: A write at offset 12 stores the trigger configuration, with pin n's mode in bits 3n+2:3n. The same offset reads it back, and bits 31:24 read zero.
- R4: A write at offset 16 stores the per-pin enable mask from bits 7:0. The same offset reads it back.
- R5: In mode 1 a pin's raw status equals its synchronized input. In mode 2 it equals the inverted synchronized input. Acknowledge does not clear either.
- R6: In mode 3 a pin's raw status reads 1 whatever its input.
- R7: Modes 5, 6 and 7 latch a rising edge, a falling edge, or either edge of the synchronized input into a sticky raw status bit. The edge is found by comparing the synchronized value with its value one clock earlier. Raw status is read at offset 24.
- R8: Writing 1 to bit n at offset 20 clears pin n's latched edge status, and writing 0 leaves it unchanged. Offset 20 reads as zero. If an edge and an acknowledge reach a pin in the same cycle, the status stays set.
- R9: Modes 0 and 4 give raw status 0. Switching a pin to any mode other than 5, 6 or 7 drops its latched edge.
- R10: A read at offset 28 returns raw status ANDed with the mask in bits 7:0.
- R11: `irq_o` is the OR of the masked status bits, delayed by one register.
- R12: Unmapped offsets read zero, `rdata_o` is zero when no read is strobed, and writes to read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous pin inputs |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset of a word register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the strobed cycle |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that the bus strobes and address are synchronous to `clk_i`. They also assume that a write carries the pin's trigger mode in the cycle it takes effect, so that the edge-latch properties can judge each edge by the mode held before that write. Only `pin_i` may change freely, and it is treated as asynchronous. The stimulus therefore drives the strobes only between clock edges. It keeps addresses on word offsets, mixing mapped and unmapped ones. It varies pins, modes, masks and acknowledges at random, and adds a directed case where an edge and an acknowledge land on the same edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF  = 3'd0,
    MODE_HIGH = 3'd1,
    MODE_LOW  = 3'd2,
    MODE_SET  = 3'd3,
    MODE_RSVD = 3'd4,
    MODE_RISE = 3'd5,
    MODE_FALL = 3'd6,
    MODE_ANY  = 3'd7
  } trig_mode_e;

  localparam int unsigned OFS_PIN    = 4;
  localparam int unsigned OFS_CFG    = 12;
  localparam int unsigned OFS_MASK   = 16;
  localparam int unsigned OFS_ACK    = 20;
  localparam int unsigned OFS_RAW    = 24;
  localparam int unsigned OFS_MASKED = 28;

  function automatic logic mode_is_edge(trig_mode_e m);
    return m[2] & (m[1] | m[0]);
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= async_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[k] <= '0;
      else         chain_q[k] <= chain_q[k-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= chain_q[STAGES-1];
  end

  assign sync_o = chain_q[STAGES-1];

  // R2: synchronized value moves into the history flop
  a_r2_prev_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> prev_o == $past(sync_o));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [NUM_PINS*MODE_W-1:0] cfg_o,
  output logic [NUM_PINS-1:0]        mask_o,
  output logic [NUM_PINS-1:0]        ack_o
);
  localparam int unsigned CFG_W = NUM_PINS * MODE_W;

  logic wr_cfg, wr_mask, wr_ack;
  assign wr_cfg  = wr_en_i && (addr_i == ADDR_W'(OFS_CFG));
  assign wr_mask = wr_en_i && (addr_i == ADDR_W'(OFS_MASK));
  assign wr_ack  = wr_en_i && (addr_i == ADDR_W'(OFS_ACK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '0;
      mask_o <= '0;
    end else begin
      if (wr_cfg)  cfg_o  <= wdata_i[CFG_W-1:0];
      if (wr_mask) mask_o <= wdata_i[NUM_PINS-1:0];
    end
  end

  // acknowledge is a one-cycle pulse, never stored
  assign ack_o = wr_ack ? wdata_i[NUM_PINS-1:0] : '0;

  if (CFG_W < DATA_W) begin : g_spare
    logic unused_wdata;
    assign unused_wdata = ^wdata_i[DATA_W-1:CFG_W];
  end

  a_r3_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cfg |=> cfg_o == $past(wdata_i[CFG_W-1:0]));
  a_r4_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> mask_o == $past(wdata_i[NUM_PINS-1:0]));
  a_r12_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cfg |=> $stable(cfg_o));
  a_r12_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask |=> $stable(mask_o));
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              lvl_i,
  input  logic              prev_i,
  input  logic              ack_i,
  output logic              raw_o
);
  trig_mode_e mode;
  logic rise, fall, hit, edge_q, edge_d;

  assign mode = trig_mode_e'(mode_i);
  assign rise = lvl_i & ~prev_i;
  assign fall = ~lvl_i & prev_i;

  always_comb begin
    unique case (mode)
      MODE_RISE: hit = rise;
      MODE_FALL: hit = fall;
      MODE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  // new edge beats a same-cycle acknowledge
  assign edge_d = mode_is_edge(mode) ? (hit | (edge_q & ~ack_i)) : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_q <= 1'b0;
    else         edge_q <= edge_d;
  end

  always_comb begin
    unique case (mode)
      MODE_HIGH: raw_o = lvl_i;
      MODE_LOW:  raw_o = ~lvl_i;
      MODE_SET:  raw_o = 1'b1;
      MODE_RISE,
      MODE_FALL,
      MODE_ANY:  raw_o = edge_q;
      default:   raw_o = 1'b0;
    endcase
  end

  a_r7_edge_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> edge_q);
  a_r7_edge_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_q && !ack_i && mode_is_edge(mode)) |=> edge_q);
  a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !hit) |=> !edge_q);
  a_r9_nonedge_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_is_edge(mode) |=> !edge_q);
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                irq_o
);
  localparam int unsigned CFG_W = NUM_PINS * MODE_W;

  logic [NUM_PINS-1:0] pin_sync, pin_prev, mask, ack, raw, masked;
  logic [CFG_W-1:0]    cfg;

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_sync),
    .prev_o  (pin_prev)
  );

  gpio_irq_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cfg_o   (cfg),
    .mask_o  (mask),
    .ack_o   (ack)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    gpio_irq_pin i_pin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (cfg[n*MODE_W +: MODE_W]),
      .lvl_i  (pin_sync[n]),
      .prev_i (pin_prev[n]),
      .ack_i  (ack[n]),
      .raw_o  (raw[n])
    );
  end

  assign masked = raw & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |masked;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        ADDR_W'(OFS_PIN):    rdata_o[NUM_PINS-1:0] = pin_sync;
        ADDR_W'(OFS_CFG):    rdata_o[CFG_W-1:0]    = cfg;
        ADDR_W'(OFS_MASK):   rdata_o[NUM_PINS-1:0] = mask;
        ADDR_W'(OFS_RAW):    rdata_o[NUM_PINS-1:0] = raw;
        ADDR_W'(OFS_MASKED): rdata_o[NUM_PINS-1:0] = masked;
        default:             rdata_o = '0;
      endcase
    end
  end

  a_r11_irq_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(raw & mask)) |=> irq_o);
  a_r11_irq_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(raw & mask)) |=> !irq_o);
  a_r12_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);
endmodule

// File: tb/test_gpio_irq_unit.sv
`timescale 1ns/1ps
module test_gpio_irq_unit;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] pin = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit model_on = 1'b0;

  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_p = '0, m_edge = '0, m_mask = '0;
  logic [23:0]  m_cfg = '0;
  logic         m_irq = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_unit i_gpio_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [2:0] mode_of(int i);
    return m_cfg[3*i +: 3];
  endfunction

  function automatic logic [N-1:0] m_raw();
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      case (mode_of(i))
        3'd1: r[i] = m_s2[i];
        3'd2: r[i] = ~m_s2[i];
        3'd3: r[i] = 1'b1;
        3'd5, 3'd6, 3'd7: r[i] = m_edge[i];
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, advanced on every clock edge, compared just after it
  always @(posedge clk) begin
    if (model_on) begin
      logic [N-1:0] ack, nedge, raw_old;
      raw_old = m_raw();
      ack = (wr_en && addr == 8'd20) ? wdata[N-1:0] : '0;
      for (int i = 0; i < N; i++) begin
        logic r, f, h, e;
        logic [2:0] md;
        md = mode_of(i);
        r = m_s2[i] & ~m_p[i];
        f = ~m_s2[i] & m_p[i];
        e = (md == 3'd5) || (md == 3'd6) || (md == 3'd7);
        h = (md == 3'd5 && r) || (md == 3'd6 && f) || (md == 3'd7 && (r || f));
        nedge[i] = e ? (h || (m_edge[i] && !ack[i])) : 1'b0;
      end
      m_irq = |(raw_old & m_mask);
      if (wr_en && addr == 8'd12) m_cfg = wdata[23:0];
      if (wr_en && addr == 8'd16) m_mask = wdata[N-1:0];
      m_edge = nedge;
      m_p = m_s2;
      m_s2 = m_s1;
      m_s1 = pin;
      #1;
      check("R11 irq", {31'd0, irq}, {31'd0, m_irq});
      if (!rd_en) check("R12 idle rdata", rdata, 32'd0);
      else begin
        case (addr)
          8'd4:  check("R2 pin data", rdata, {24'd0, m_s2});
          8'd12: check("R3 cfg readback", rdata, {8'd0, m_cfg});
          8'd16: check("R4 mask readback", rdata, {24'd0, m_mask});
          8'd20: check("R8 ack reads zero", rdata, 32'd0);
          8'd28: check("R10 masked", rdata, {24'd0, m_raw() & m_mask});
          8'd24: begin
            logic [N-1:0] rw;
            rw = m_raw();
            check("R12 raw upper", {8'd0, rdata[31:8]}, 32'd0);
            for (int i = 0; i < N; i++) begin
              case (mode_of(i))
                3'd1, 3'd2: check("R5 level", {31'd0, rdata[i]}, {31'd0, rw[i]});
                3'd3:       check("R6 set", {31'd0, rdata[i]}, {31'd0, rw[i]});
                3'd5, 3'd6, 3'd7: check("R7/R8 edge", {31'd0, rdata[i]}, {31'd0, rw[i]});
                default:    check("R9 off", {31'd0, rdata[i]}, {31'd0, rw[i]});
              endcase
            end
          end
          default: check("R12 unmapped", rdata, 32'd0);
        endcase
      end
    end
  end

  task automatic bus(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a);
    bus(1'b0, 1'b1, a, 32'd0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus(1'b1, 1'b0, a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pack;
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports
    rd_en = 1'b1; addr = 8'd24; #1;
    check("R1 raw at reset", rdata, 32'd0);
    check("R1 irq at reset", {31'd0, irq}, 32'd0);
    addr = 8'd12; #1;
    check("R1 cfg at reset", rdata, 32'd0);
    rd_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;

    // R1 after release, then every mode on its own pin (pin i gets mode i)
    rd(8'd16); rd(8'd28);
    pack = '0;
    for (int i = 0; i < N; i++) pack[3*i +: 3] = 3'(i);
    wr(8'd12, pack | 32'hFF00_0000);
    wr(8'd16, 32'hFFFF_FFFF);
    for (int k = 0; k < 40; k++) begin
      pin = 8'(k * 37) ^ {k[0], 7'd0};
      rd(8'(4 * (k % 8)));
    end
    // R8: acknowledge with ones and zeros, read raw around it
    pin = 8'hFF; rd(8'd24); rd(8'd24); rd(8'd24);
    wr(8'd20, 32'h0000_0000); rd(8'd24);
    wr(8'd20, 32'h0000_00FF); rd(8'd24); rd(8'd20);
    // R12: writes to read-only offsets
    wr(8'd24, 32'hFFFF_FFFF); wr(8'd28, 32'hFFFF_FFFF); wr(8'd4, 32'hFF);
    rd(8'd12); rd(8'd16); rd(8'd24);

    // R8: edge and acknowledge on the same clock edge
    wr(8'd12, 32'h00FF_FFFF);
    pin = 8'h00;
    repeat (4) rd(8'd24);
    wr(8'd20, 32'hFF);
    pin = 8'hFF;
    rd(8'd24); rd(8'd24);
    wr(8'd20, 32'hFF);
    rd(8'd24); rd(8'd28);
    wr(8'd20, 32'hFF); rd(8'd24);

    // R9: leaving edge mode drops status
    pin = 8'h00; rd(8'd24); rd(8'd24); rd(8'd24);
    wr(8'd12, 32'h0092_4924);
    rd(8'd24);
    wr(8'd12, 32'h00FF_FFFF); rd(8'd24);

    // random traffic over all offsets
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      if (rv[3:0] == 4'd0) pin = 8'($urandom);
      else if (rv[3:0] < 4'd4) pin = pin ^ (8'd1 << rv[6:4]);
      case (rv[10:8])
        3'd0: wr(8'd12, $urandom);
        3'd1: wr(8'd16, $urandom);
        3'd2: wr(8'd20, $urandom);
        3'd3: wr(8'({rv[15:13], 2'b00}), $urandom);
        default: rd(8'({rv[15:13], 2'b00}));
      endcase
    end
    bus(1'b0, 1'b0, 8'd0, 32'd0);
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule